// File: doc/BRIEF.md
# Sparsifying Readout Formatter

The formatter takes one frame of digitised 8-bit samples, one per channel, and turns it into a byte stream for a shared output bus. A frame is stored on a valid/ready handshake. The block then waits for a readout token. When the token arrives it sends a two-byte header, made of a chip identifier and a cell identifier. After the header it sends one channel/data byte pair for each selected channel, in ascending channel order. It then passes the token on and stops driving the bus.

There are three selection modes. Read-all sends every channel. Sparse sends only the channels whose sample is strictly above a threshold. Nearest-neighbour sends those channels and also the channels on either side of them. In nearest-neighbour mode, the edge channels connect to the adjacent chips in a chain. A hit on the lowest or highest channel raises a flag toward the lower or upper neighbour. A flag that comes in from a neighbour adds the matching edge channel to this chip's readout. A chip configured as first or last in the chain always sends its lowest or highest channel, respectively.

Output rules for back-pressure: a byte is transferred on a clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the byte and its strobe hold still. The input side follows the same rule: a frame is taken on an edge where `frame_valid` and `frame_ready` are both high, and `frame_ready` is high only while the block is idle.

Top module: `rof_fmt`

## Requirements
- R1: Mode 2'b00 (read-all) sends a pair for every channel, from channel 0 upward.
- R2: Mode 2'b01 (sparse) sends only channels whose sample is strictly greater than `thresh`; a sample equal to it is not sent.
- R3: When `thresh` is greater than `modulo`, no channel counts as a hit, so a sparse frame with no forced edges sends only the header.
- R4: Mode 2'b10 or 2'b11 (nearest-neighbour) sends every hit channel and the channels directly above and below each hit.
- R5: In nearest-neighbour mode, `nbr_lo_out` / `nbr_hi_out` are high from frame load until the token is passed if channel 0 / channel NCH-1 is a hit. A high `nbr_lo_in` / `nbr_hi_in` at token arrival adds channel 0 / channel NCH-1.
- R6: The header is `chip_id` followed by `cell_id` with bits 7:6 forced to zero.
- R7: Each pair is the channel number in binary, zero-extended, followed by the sample in Gray code (g = d ^ (d >> 1)).
- R8: `out_odd` is 1 on the first byte of every pair (chip-ID, channel) and 0 on the second (cell-ID, data).
- R9: Nothing is driven (`out_en`=0, `out_valid`=0) before `token_in`. One cycle after the last byte is accepted, `token_out` pulses for exactly one cycle, and `out_en` is low after that.
- R10: `first_chip` forces channel 0 and `last_chip` forces channel NCH-1 into the readout in every mode.
- R11: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_odd` stay unchanged.
- R12: `frame_ready` is high in idle only; a frame is stored on `frame_valid && frame_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 read-all, 01 sparse, 1x nearest-neighbour |
| thresh | input | 8 | Hit threshold (strictly greater) |
| modulo | input | 8 | Converter count ceiling |
| chip_id | input | 8 | Header byte 0 |
| cell_id | input | 8 | Header byte 1, bits 5:0 used |
| first_chip | input | 1 | Force lowest channel |
| last_chip | input | 1 | Force highest channel |
| frame_valid | input | 1 | Frame offered |
| frame_ready | output | 1 | Frame can be taken |
| adc_flat | input | NCH*8 | Samples, channel i at bits [8i+7:8i] |
| token_in | input | 1 | Readout token from previous chip |
| token_out | output | 1 | One-cycle token to next chip |
| nbr_lo_in | input | 1 | Hit flag from lower neighbour |
| nbr_hi_in | input | 1 | Hit flag from upper neighbour |
| nbr_lo_out | output | 1 | Channel 0 hit flag |
| nbr_hi_out | output | 1 | Highest channel hit flag |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Byte accepted |
| out_byte | output | 8 | Stream byte |
| out_odd | output | 1 | First byte of a pair |
| out_en | output | 1 | Bus drive enable |

## Verification
The bench builds the block with NCH=8. That keeps the expected streams short, and it puts both edge channels and their neighbours within a few bytes of each other. Channel 0 and channel 7 can then be hit, forced and fed by neighbour flags in the same frame. Those are the cases where the neighbour-window and forcing logic meet. A back-pressure pattern on the read-all stream exercises the hold behaviour on header, channel and data bytes alike.

// File: rtl/rof_pkg.sv
package rof_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_HID, ST_HCELL, ST_CHAN, ST_DATA, ST_PASS
  } rof_state_e;

  localparam logic [1:0] MODE_ALL    = 2'b00;
  localparam logic [1:0] MODE_SPARSE = 2'b01;

  function automatic logic [7:0] to_gray(input logic [7:0] d);
    return d ^ (d >> 1);
  endfunction
endpackage

// File: rtl/rof_sel.sv
module rof_sel #(
  parameter int NCH = 128,
  parameter int DW  = 8
) (
  input  logic [NCH*DW-1:0] adc_flat,
  input  logic [1:0]        mode,
  input  logic [DW-1:0]     thresh,
  input  logic [DW-1:0]     modulo,
  input  logic              force_lo,
  input  logic              force_hi,
  output logic [NCH-1:0]    send_mask,
  output logic              hit_lo,
  output logic              hit_hi
);
  import rof_pkg::*;

  logic [NCH-1:0] hit;
  logic           all_m;
  logic           nn_m;
  logic           thr_ok;

  assign all_m  = (mode == MODE_ALL);
  assign nn_m   = mode[1];
  assign thr_ok = !(thresh > modulo);

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = thr_ok && (adc_flat[i*DW +: DW] > thresh);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    logic below, above, forced;
    if (i > 0) begin : g_b
      assign below = hit[i-1];
    end else begin : g_nb
      assign below = 1'b0;
    end
    if (i < NCH-1) begin : g_a
      assign above = hit[i+1];
    end else begin : g_na
      assign above = 1'b0;
    end
    if (i == 0) begin : g_f0
      assign forced = force_lo;
    end else if (i == NCH-1) begin : g_fn
      assign forced = force_hi;
    end else begin : g_ff
      assign forced = 1'b0;
    end
    assign send_mask[i] = all_m | hit[i] | (nn_m & (below | above)) | forced;
  end

  assign hit_lo = nn_m & hit[0];
  assign hit_hi = nn_m & hit[NCH-1];
endmodule

// File: rtl/rof_prio.sv
module rof_prio #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rof_fmt.sv
module rof_fmt #(
  parameter int NCH       = 128,
  parameter int DW        = 8,
  parameter int CELL_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DW-1:0]     thresh,
  input  logic [DW-1:0]     modulo,
  input  logic [DW-1:0]     chip_id,
  input  logic [DW-1:0]     cell_id,
  input  logic              first_chip,
  input  logic              last_chip,
  input  logic              frame_valid,
  output logic              frame_ready,
  input  logic [NCH*DW-1:0] adc_flat,
  input  logic              token_in,
  output logic              token_out,
  input  logic              nbr_lo_in,
  input  logic              nbr_hi_in,
  output logic              nbr_lo_out,
  output logic              nbr_hi_out,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_byte,
  output logic              out_odd,
  output logic              out_en
);
  import rof_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam logic [DW-1:0] CELL_MASK = DW'((1 << CELL_BITS) - 1);

  rof_state_e      state;
  logic [NCH*DW-1:0] adc_q;
  logic [NCH-1:0]  pending;
  logic [NCH-1:0]  sel_mask;
  logic [CHW-1:0]  cur;
  logic [CHW-1:0]  nxt_idx;
  logic            nxt_any;
  logic            nn_q;
  logic            sel_lo, sel_hi;
  logic            lo_q, hi_q;
  logic [DW-1:0]   cur_val;

  rof_sel #(.NCH(NCH), .DW(DW)) u_sel (
    .adc_flat (adc_flat),
    .mode     (mode),
    .thresh   (thresh),
    .modulo   (modulo),
    .force_lo (first_chip),
    .force_hi (last_chip),
    .send_mask(sel_mask),
    .hit_lo   (sel_lo),
    .hit_hi   (sel_hi)
  );

  rof_prio #(.N(NCH), .IW(CHW)) u_prio (
    .vec(pending),
    .idx(nxt_idx),
    .any(nxt_any)
  );

  assign cur_val = adc_q[cur*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= '0;
      cur     <= '0;
      nn_q    <= 1'b0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
      adc_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (frame_valid) begin
          adc_q   <= adc_flat;
          pending <= sel_mask;
          lo_q    <= sel_lo;
          hi_q    <= sel_hi;
          nn_q    <= mode[1];
          state   <= ST_ARMED;
        end
        ST_ARMED: if (token_in) begin
          pending[0]     <= pending[0] | (nn_q & nbr_lo_in);
          pending[NCH-1] <= pending[NCH-1] | (nn_q & nbr_hi_in);
          state          <= ST_HID;
        end
        ST_HID: if (out_ready) state <= ST_HCELL;
        ST_HCELL, ST_DATA: if (out_ready) begin
          if (nxt_any) begin
            cur   <= nxt_idx;
            state <= ST_CHAN;
          end else begin
            state <= ST_PASS;
          end
        end
        ST_CHAN: if (out_ready) begin
          pending[cur] <= 1'b0;
          state        <= ST_DATA;
        end
        ST_PASS: begin
          lo_q  <= 1'b0;
          hi_q  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_byte = '0;
    out_odd  = 1'b0;
    case (state)
      ST_HID:   begin out_byte = chip_id;             out_odd = 1'b1; end
      ST_HCELL: out_byte = cell_id & CELL_MASK;
      ST_CHAN:  begin out_byte = DW'(cur);            out_odd = 1'b1; end
      ST_DATA:  out_byte = to_gray(cur_val);
      default:  ;
    endcase
  end

  assign out_valid   = (state == ST_HID) || (state == ST_HCELL) ||
                       (state == ST_CHAN) || (state == ST_DATA);
  assign out_en      = out_valid;
  assign frame_ready = (state == ST_IDLE);
  assign token_out   = (state == ST_PASS);
  assign nbr_lo_out  = lo_q;
  assign nbr_hi_out  = hi_q;

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_odd)));

  assert_pair_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_odd) |=> (out_valid && !out_odd));

  assert_token_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> (!token_out && !out_en));

  assert_busy_no_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !frame_ready);

  assert_chan_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHAN) |-> pending[cur]);

  assert_token_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ARMED && !$past(token_in)) |-> !out_en);
endmodule

// File: tb/tb_rof_fmt.sv
module tb_rof_fmt;
  localparam int NCH = 8;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] thresh = 8'd0, modulo = 8'd255, chip_id = 8'h5A, cell_id = 8'hFF;
  logic first_chip = 1'b0, last_chip = 1'b0;
  logic frame_valid = 1'b0;
  logic frame_ready;
  logic [NCH*DW-1:0] adc_flat = '0;
  logic token_in = 1'b0, token_out;
  logic nbr_lo_in = 1'b0, nbr_hi_in = 1'b0, nbr_lo_out, nbr_hi_out;
  logic out_valid, out_ready = 1'b0, out_odd, out_en;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  logic [7:0] smp [NCH];
  logic [7:0] exp_b [64];
  int exp_n;

  always #10 clk = ~clk;

  rof_fmt #(.NCH(NCH), .DW(DW)) dut (.*);

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] gray(input logic [7:0] d);
    logic [7:0] g;
    for (int i = 0; i < 8; i++) g[i] = (i == 7) ? d[7] : (d[i] ^ d[i+1]);
    return g;
  endfunction

  task automatic build_expected();
    logic hit [NCH];
    logic snd;
    exp_n = 0;
    exp_b[exp_n++] = chip_id;
    exp_b[exp_n++] = {2'b00, cell_id[5:0]};
    for (int i = 0; i < NCH; i++) hit[i] = (thresh <= modulo) && (smp[i] > thresh);
    for (int i = 0; i < NCH; i++) begin
      snd = (mode == 2'b00) || hit[i];
      if (mode[1] && i > 0 && hit[i-1]) snd = 1'b1;
      if (mode[1] && i < NCH-1 && hit[i+1]) snd = 1'b1;
      if (i == 0 && (first_chip || (mode[1] && nbr_lo_in))) snd = 1'b1;
      if (i == NCH-1 && (last_chip || (mode[1] && nbr_hi_in))) snd = 1'b1;
      if (snd) begin
        exp_b[exp_n++] = 8'(i);
        exp_b[exp_n++] = gray(smp[i]);
      end
    end
  endtask

  task automatic run_frame(input string req, input logic bp,
                           input logic exp_lo, input logic exp_hi);
    logic [7:0] got_b [64];
    logic       got_o [64];
    int n = 0;
    int cyc = 0;
    logic stalled = 1'b0, saw_tok = 1'b0;
    logic [7:0] pb;
    logic po;
    for (int i = 0; i < NCH; i++) adc_flat[i*DW +: DW] = smp[i];
    build_expected();
    @(negedge clk);
    chk({req, " frame_ready idle R12"}, frame_ready, 1'b1);
    frame_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_valid = 1'b0;
    chk({req, " frame_ready armed R12"}, frame_ready, 1'b0);
    chk({req, " nbr_lo_out R5"}, nbr_lo_out, exp_lo);
    chk({req, " nbr_hi_out R5"}, nbr_hi_out, exp_hi);
    repeat (3) @(negedge clk);
    chk({req, " no drive before token R9"}, {out_en, out_valid}, 2'b00);
    token_in = 1'b1;
    @(posedge clk); @(negedge clk);
    token_in = 1'b0;
    while (cyc < 400) begin
      if (token_out) begin saw_tok = 1'b1; break; end
      if (stalled) begin
        chk({req, " hold byte R11"}, {out_valid, out_odd, out_byte}, {1'b1, po, pb});
      end
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (out_valid && out_ready && n < 64) begin
        got_b[n] = out_byte; got_o[n] = out_odd; n++;
      end
      stalled = out_valid && !out_ready;
      pb = out_byte; po = out_odd;
      cyc++;
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk({req, " token passed R9"}, saw_tok, 1'b1);
    chk({req, " byte count R1 R2 R4"}, n, exp_n);
    for (int k = 0; k < n && k < exp_n; k++) begin
      chk({req, (k < 2) ? " header R6" : " pair R7"}, got_b[k], exp_b[k]);
      chk({req, " odd strobe R8"}, got_o[k], (k % 2 == 0));
    end
    @(negedge clk);
    chk({req, " token one cycle R9"}, {token_out, out_en}, 2'b00);
    chk({req, " back to idle R12"}, frame_ready, 1'b1);
    chk({req, " flags cleared R5"}, {nbr_lo_out, nbr_hi_out}, 2'b00);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("reset R12", {frame_ready, out_valid, token_out, out_en}, 4'b1000);
  endtask

  task automatic t_readall();
    mode = 2'b00; cell_id = 8'hFF; chip_id = 8'h5A;
    for (int i = 0; i < NCH; i++) smp[i] = 8'(i * 37 + 3);
    run_frame("R1 readall", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sparse();
    mode = 2'b01; thresh = 8'd50; modulo = 8'd255; chip_id = 8'h11; cell_id = 8'hC7;
    smp = '{8'd10, 8'd51, 8'd50, 8'd200, 8'd0, 8'd49, 8'd255, 8'd50};
    run_frame("R2 sparse", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_thr_over_mod();
    mode = 2'b01; thresh = 8'd200; modulo = 8'd100;
    for (int i = 0; i < NCH; i++) smp[i] = 8'd255;
    run_frame("R3 thr>modulo", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_nn_mid();
    mode = 2'b10; thresh = 8'd100; modulo = 8'd255;
    smp = '{8'd0, 8'd5, 8'd9, 8'd150, 8'd7, 8'd1, 8'd3, 8'd180};
    run_frame("R4 nn hits 3 and 7", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_nn_edges();
    mode = 2'b11; thresh = 8'd100; nbr_hi_in = 1'b1;
    smp = '{8'd120, 8'd5, 8'd9, 8'd10, 8'd7, 8'd1, 8'd3, 8'd2};
    run_frame("R5 nn edge flags", 1'b0, 1'b1, 1'b0);
    nbr_hi_in = 1'b0;
  endtask

  task automatic t_sparse_nbr_ignored();
    mode = 2'b01; thresh = 8'd100; nbr_lo_in = 1'b1; nbr_hi_in = 1'b1;
    smp = '{8'd120, 8'd5, 8'd9, 8'd10, 8'd7, 8'd1, 8'd3, 8'd220};
    run_frame("R5 sparse no flags", 1'b0, 1'b0, 1'b0);
    nbr_lo_in = 1'b0; nbr_hi_in = 1'b0;
  endtask

  task automatic t_force();
    mode = 2'b01; thresh = 8'd250; first_chip = 1'b1; last_chip = 1'b1;
    for (int i = 0; i < NCH; i++) smp[i] = 8'(i + 1);
    run_frame("R10 forced edges", 1'b0, 1'b0, 1'b0);
    first_chip = 1'b0; last_chip = 1'b0;
  endtask

  task automatic t_backpressure();
    mode = 2'b00; chip_id = 8'hA3; cell_id = 8'h40;
    for (int i = 0; i < NCH; i++) smp[i] = 8'(255 - i * 29);
    run_frame("R11 backpressure", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_readall();
    t_sparse();
    t_thr_over_mod();
    t_nn_mid();
    t_nn_edges();
    t_sparse_nbr_ignored();
    t_force();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule